// File: doc/BRIEF.md
# PWM Channel Pulse Comparator

This block is the per-channel stage of a pulse-width modulator that several channels share a single phase counter with. On every clock it compares the shared phase count against the channel's phase delay (the rising point) and against the delay plus the current duty cycle (the falling point). It keeps a pulse level that it sets on the first match and clears on the second. It then applies the channel enable and a per-channel polarity inversion, and drives the result through one output register. A pulse whose falling point lies past the end of the cycle wraps around, so the output is still high when the next cycle begins.

A resolution setting picks how many of the most significant bits take part in the comparisons. This lets a faster pulse rate use a coarser duty step. The phase counter, the source of the duty cycle and any register access sit outside this block. The block takes them as plain inputs.

Top module: `pwm_chan_pulse`

## Requirements
- R1: While `rst_i` is high at a rising edge, `pwm_o` is 0 after that edge and the pulse level is cleared, whatever the state of `invert_i`.
- R2: When the masked phase equals the masked delay and the masked phase differs from the masked fall point, the pulse level becomes 1.
- R3: When the masked phase equals the masked fall point, the pulse level becomes 0. The fall point is `(delay_i + duty_i) mod 2^CNT_W`, masked.
- R4: A resolution code `r` keeps only the top `r+1` bits of the phase, the delay and the fall point in the comparisons. Codes at or above `CNT_W-1` keep every bit, and lower bits have no effect on the output. In all other beats the level holds its previous value.
- R5: When the masked delay equals the masked fall point (for example, a zero duty cycle), rise and fall coincide and the level stays 0.
- R6: A pulse whose fall point wraps past the end of the cycle stays high through phase 0 and falls in the following cycle.
- R7: While `cntr_en_i` is low, the pulse level is forced to 0.
- R8: While `chan_en_i` is low, `pwm_o` equals `invert_i` (no pulses). Level tracking continues, so re-enabling shows the current level on the next clock.
- R9: With `invert_i` high and the channel enabled, `pwm_o` is the complement of the pulse level.
- R10: `pwm_o` reflects the inputs present before a rising edge only after that edge: exactly one register of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cntr_en_i | input | 1 | Shared phase counter running |
| phase_i | input | CNT_W | Shared phase count |
| res_i | input | RES_W | Resolution code r, r+1 top bits compared |
| delay_i | input | CNT_W | Channel phase delay (rise point) |
| duty_i | input | CNT_W | Current channel duty cycle |
| chan_en_i | input | 1 | Channel output enable |
| invert_i | input | 1 | Channel output polarity invert |
| pwm_o | output | 1 | Registered channel output |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it, because the level and the output both update on that edge from a purely combinational comparison. The bench drives all inputs at the falling edge and advances its own level model once per clock. It samples `pwm_o` 2 ns after the next rising edge, and for the latency case it also samples just before that edge to show the output has not yet moved. The sweep covers every resolution code over two full pulse cycles, with random noise in the phase's unused low bits. Each sample is tagged with the rise, fall, wrap, zero-width or inversion requirement it shows.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

  // Result of the per-beat threshold comparison.
  typedef enum logic [1:0] {
    EV_HOLD = 2'd0,
    EV_RISE = 2'd1,
    EV_FALL = 2'd2
  } edge_ev_t;

endpackage

// File: rtl/pwm_res_mask.sv
// Builds the bit mask that keeps the top (res+1) bits of a CNT_W value.
module pwm_res_mask #(
  parameter int CNT_W = 16,
  parameter int RES_W = 4
) (
  input  logic [RES_W-1:0] res_i,
  output logic [CNT_W-1:0] mask_o
);

  localparam int LAST_BIT = CNT_W - 1;

  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    // bit i survives when it lies within the top res+1 positions
    assign mask_o[i] = ((int'(res_i) + i) >= LAST_BIT);
  end

endmodule

// File: rtl/pwm_edge_find.sv
// Compares the masked phase against the masked rise and fall points.
module pwm_edge_find
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] mask_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] duty_i,
  output edge_ev_t         ev_o
);

  logic [CNT_W-1:0] fall_pt;
  logic             hit_rise;
  logic             hit_fall;

  assign fall_pt  = delay_i + duty_i;
  assign hit_rise = ((phase_i & mask_i) == (delay_i & mask_i));
  assign hit_fall = ((phase_i & mask_i) == (fall_pt & mask_i));

  // fall has priority: coinciding points give a zero-width pulse
  always_comb begin
    if (hit_fall)      ev_o = EV_FALL;
    else if (hit_rise) ev_o = EV_RISE;
    else               ev_o = EV_HOLD;
  end

endmodule

// File: rtl/pwm_level_track.sv
// Holds the pulse level between edges; cleared while the counter is stopped.
module pwm_level_track
  import pwm_cmp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     cntr_en_i,
  input  edge_ev_t ev_i,
  output logic     level_d_o
);

  logic level_q;

  always_comb begin
    if (!cntr_en_i)           level_d_o = 1'b0;
    else if (ev_i == EV_FALL) level_d_o = 1'b0;
    else if (ev_i == EV_RISE) level_d_o = 1'b1;
    else                      level_d_o = level_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) level_q <= 1'b0;
    else       level_q <= level_d_o;
  end

  p_cntr_off_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !cntr_en_i |=> !level_q);

  p_fall_wins_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (cntr_en_i && ev_i == EV_FALL) |=> !level_q);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (cntr_en_i && ev_i == EV_HOLD && !$past(rst_i)) |=> (level_q == $past(level_q)));

endmodule

// File: rtl/pwm_out_stage.sv
// Channel gating, polarity and the output register.
module pwm_out_stage (
  input  logic clk_i,
  input  logic rst_i,
  input  logic level_i,
  input  logic chan_en_i,
  input  logic invert_i,
  output logic pwm_o
);

  logic pre_out;

  assign pre_out = (chan_en_i ? level_i : 1'b0) ^ invert_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) pwm_o <= 1'b0;
    else       pwm_o <= pre_out;
  end

  p_chan_off_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !chan_en_i |=> (pwm_o == $past(invert_i)));

  p_invert_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (chan_en_i && invert_i) |=> (pwm_o == !$past(level_i)));

endmodule

// File: rtl/pwm_chan_pulse.sv
module pwm_chan_pulse
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RES_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             cntr_en_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             chan_en_i,
  input  logic             invert_i,
  output logic             pwm_o
);

  logic [CNT_W-1:0] cmp_mask;
  edge_ev_t         ev;
  logic             level_d;

  pwm_res_mask #(.CNT_W(CNT_W), .RES_W(RES_W)) i_mask (
    .res_i  (res_i),
    .mask_o (cmp_mask)
  );

  pwm_edge_find #(.CNT_W(CNT_W)) i_edge (
    .mask_i  (cmp_mask),
    .phase_i (phase_i),
    .delay_i (delay_i),
    .duty_i  (duty_i),
    .ev_o    (ev)
  );

  pwm_level_track i_track (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cntr_en_i (cntr_en_i),
    .ev_i      (ev),
    .level_d_o (level_d)
  );

  pwm_out_stage i_out (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .level_i   (level_d),
    .chan_en_i (chan_en_i),
    .invert_i  (invert_i),
    .pwm_o     (pwm_o)
  );

  // A rise seen before an edge shows on the pin right after it.
  p_rise_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (cntr_en_i && chan_en_i && ev == EV_RISE) |=> (pwm_o != $past(invert_i)));

  p_reset_low_r1: assert property (@(posedge clk_i)
    rst_i |=> !pwm_o);

endmodule

// File: tb/test_pwm_chan_pulse.sv
module test_pwm_chan_pulse;

  localparam int W  = 6;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          cntr_en;
  logic [W-1:0]  phase;
  logic [RW-1:0] res;
  logic [W-1:0]  delay;
  logic [W-1:0]  duty;
  logic          chan_en;
  logic          invert;
  logic          pwm;

  int  n_tests = 0;
  int  n_fail  = 0;
  logic st = 1'b0;

  always #4 clk = ~clk;

  pwm_chan_pulse #(.CNT_W(W), .RES_W(RW)) i_pwm_chan_pulse (
    .clk_i     (clk),
    .rst_i     (rst),
    .cntr_en_i (cntr_en),
    .phase_i   (phase),
    .res_i     (res),
    .delay_i   (delay),
    .duty_i    (duty),
    .chan_en_i (chan_en),
    .invert_i  (invert),
    .pwm_o     (pwm)
  );

  function automatic logic [W-1:0] keep_mask(input int r);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (r + i >= W - 1);
    return m;
  endfunction

  function automatic logic model_raw(input logic prev);
    logic [W-1:0] m;
    logic [W-1:0] fp;
    m  = keep_mask(int'(res));
    fp = delay + duty;
    if (!cntr_en)                    return 1'b0;
    if ((phase & m) == (fp & m))     return 1'b0;
    if ((phase & m) == (delay & m))  return 1'b1;
    return prev;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pwm actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Called at a falling edge: apply phase, step model, check after rising edge.
  task automatic tick(input logic [W-1:0] ph, input string tag);
    logic raw;
    logic exp;
    string t;
    phase = ph;
    raw = model_raw(st);
    if (rst) begin
      exp = 1'b0;
      raw = 1'b0;
    end else begin
      exp = chan_en ? (raw ^ invert) : invert;
    end
    t = tag;
    if (t == "") begin
      if (raw && !st)      t = "R2";
      else if (!raw && st) t = "R3";
      else                 t = "R4";
    end
    st = raw;
    @(posedge clk);
    #2;
    check(pwm, exp, t);
    @(negedge clk);
  endtask

  task automatic run_combo(input int r, input int dl, input int du, input logic inv);
    int rr;
    int step;
    int beats;
    logic [W-1:0] m;
    string tag;
    rr    = (r > W - 1) ? W - 1 : r;
    step  = 1 << (W - 1 - rr);
    beats = 1 << (rr + 1);
    res   = RW'(r);
    delay = W'(dl);
    duty  = W'(du);
    invert = inv;
    chan_en = 1'b1;
    m = keep_mask(r);
    tag = "";
    if ((delay & m) == (W'(delay + duty) & m))          tag = "R5";
    else if (int'(delay & m) + int'(duty) >= (1 << W))  tag = "R6";
    else if (inv)                                       tag = "R9";
    cntr_en = 1'b0;
    tick('0, "R7");
    cntr_en = 1'b1;
    for (int c = 0; c < 2 * beats; c++) begin
      tick(W'((c * step) % (1 << W)) | W'($urandom % step), tag);
    end
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; cntr_en = 1'b1; phase = '0; res = RW'(W - 1);
    delay = '0; duty = W'(8); chan_en = 1'b1; invert = 1'b1;
    @(negedge clk);
    tick('0, "R1");
    tick('0, "R1");
    rst = 1'b0;
    invert = 1'b0;

    // R10: one register of delay from a matching phase to the pin
    delay = W'(10); duty = W'(5);
    for (int p = 0; p < 10; p++) tick(W'(p), "R10");
    phase = W'(10);
    #1;
    check(pwm, 1'b0, "R10");
    tick(W'(10), "R10");
    check(pwm, 1'b1, "R10");

    // R7: stopping the counter forces the level low
    cntr_en = 1'b0;
    tick('0, "R7");
    cntr_en = 1'b1;
    for (int p = 0; p < 12; p++) tick(W'(p), "");

    // R8: disable mid-pulse, then re-enable keeps tracked level
    chan_en = 1'b0;
    tick(W'(12), "R8");
    invert = 1'b1;
    tick(W'(13), "R8");
    invert = 1'b0;
    chan_en = 1'b1;
    tick(W'(14), "R8");
    tick(W'(15), "R3");

    // Sweep every resolution code with many delay / duty pairs.
    for (int r = 0; r < (1 << RW); r++) begin
      for (int dl = 0; dl < (1 << W); dl += 5) begin
        for (int du = 0; du < (1 << W); du += 7) begin
          run_combo(r, dl, du, logic'((dl + du) % 3 == 0));
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule